// File: doc/BRIEF.md
# Endpoint FIFO Programmable Flag Generator

This block watches the live counters of one endpoint FIFO and turns them into three registered status flags: a programmable-level flag, an empty flag and a full flag. The programmable flag compares a level taken from a 13-bit threshold field against one of three measures. Which measure applies depends on the endpoint direction and a mode bit. An IN endpoint in packet mode measures whole committed packets plus the bytes of the packet still being filled. An IN endpoint in byte mode measures the total bytes held. An OUT endpoint measures total bytes against the full 13-bit level.

For an IN endpoint the upper three bits of the threshold field carry a packet count (0 to 4) and only the lower ten bits carry a byte level. Each direction has an early-warning enable. When the enable for the configured direction is set, empty is reported one entry before true empty and full one entry before true full. The three flags are also packed into one nibble of an 8-bit status byte, so that a register block can merge two endpoints into one readable byte.

Top module: `ep_flag_gen`

## Requirements
- R1: After reset, and before any clock edge that follows it, flag_empty=1, flag_full=0, flag_prog=0.
- R2: IN endpoint with cfg_bytes_only=0: let N be cfg_thresh[12:10]. flag_prog is 1 when fifo_pkts > N, or when fifo_pkts == N and fifo_cur_bytes >= cfg_thresh[9:0]; otherwise 0.
- R3: In the mode of R2, an N of 5, 6 or 7 behaves exactly as N = 4.
- R4: IN endpoint with cfg_bytes_only=1: flag_prog is 1 exactly when fifo_total >= cfg_thresh[9:0]. cfg_thresh[12:10], fifo_pkts and fifo_cur_bytes have no effect.
- R5: OUT endpoint (cfg_is_in=0): flag_prog is 1 exactly when fifo_total >= cfg_thresh[12:0]. cfg_bytes_only, fifo_pkts and fifo_cur_bytes have no effect.
- R6: The early enable is cfg_in_early for an IN endpoint and cfg_out_early for an OUT endpoint. flag_empty is 1 when fifo_total == 0, or, with the early enable set, when fifo_total <= 1.
- R7: flag_full is 1 when fifo_total >= fifo_depth, or, with the early enable set, when fifo_total + 1 >= fifo_depth.
- R8: All three flags take the value computed from the inputs present at one rising clock edge, and show it from that edge on (one cycle of latency).
- R9: status_byte holds {0, flag_prog, flag_empty, flag_full} in bits [3:0] when SLOT=0, or in bits [7:4] when SLOT=1. The other nibble is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_is_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_bytes_only | input | 1 | IN only: 1 = compare total bytes, 0 = packets plus partial bytes |
| cfg_thresh | input | 13 | Threshold field; for IN, [12:10] is the packet count and [9:0] the byte level |
| cfg_in_early | input | 1 | Early empty/full enable used when the endpoint is IN |
| cfg_out_early | input | 1 | Early empty/full enable used when the endpoint is OUT |
| fifo_pkts | input | PKT_W | Committed packets in the FIFO |
| fifo_cur_bytes | input | CNT_W | Bytes in the packet being filled |
| fifo_total | input | CNT_W | Total bytes in the FIFO |
| fifo_depth | input | CNT_W | FIFO capacity in bytes |
| flag_prog | output | 1 | Programmable-level flag |
| flag_empty | output | 1 | Empty flag |
| flag_full | output | 1 | Full flag |
| status_byte | output | 8 | Packed flag nibble for host readback |

## Verification
The bench goes after the packet-count boundary in packet mode: committed packets equal to the setting with the partial bytes just below, at, and just above the level. A design that compares the wrong measure asserts the flag one packet early or late there. Packet encodings 5 to 7 are driven with committed counts of 4 and 5. A design without clamping compares against 5 to 7 and leaves the flag low. In byte and OUT modes the bench sets the ignored fields to extreme values, so a design that leaks the packet bits into the level reports a wrong flag. Totals of 0, 1, depth-1 and depth are driven with each direction's early enable on and off, both directions crossed. A design that picks the wrong direction's enable, or shifts the bound the wrong way, shows empty or full one entry off.

// File: rtl/ep_flag_pkg.sv
package ep_flag_pkg;

   localparam int unsigned THRESH_W    = 13;
   localparam int unsigned IN_LVL_W    = 10;
   localparam int unsigned PKT_SEL_W   = 3;
   localparam int unsigned PKT_SEL_MAX = 4;

   typedef struct packed {
      logic prog;
      logic empty;
      logic full;
   } flag_set_t;

   function automatic logic [PKT_SEL_W-1:0] clamp_pkt_sel(input logic [PKT_SEL_W-1:0] raw);
      if (raw > PKT_SEL_W'(PKT_SEL_MAX))
         return PKT_SEL_W'(PKT_SEL_MAX);
      return raw;
   endfunction

endpackage

// File: rtl/epf_level_cmp.sv
module epf_level_cmp
   import ep_flag_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PKT_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                is_in,
   input  logic                bytes_only,
   input  logic [THRESH_W-1:0] thresh,
   input  logic [PKT_W-1:0]    pkts,
   input  logic [CNT_W-1:0]    cur_bytes,
   input  logic [CNT_W-1:0]    total,
   output logic                prog_q
);

   logic [PKT_SEL_W-1:0] sel;
   logic [CNT_W-1:0]     in_lvl;
   logic [CNT_W-1:0]     out_lvl;
   logic                 pkt_hit;
   logic                 prog_nxt;
   logic                 seen_q;

   always_comb begin
      sel     = clamp_pkt_sel(thresh[THRESH_W-1:IN_LVL_W]);
      in_lvl  = CNT_W'(thresh[IN_LVL_W-1:0]);
      out_lvl = CNT_W'(thresh);
      pkt_hit = (pkts > PKT_W'(sel)) ||
                ((pkts == PKT_W'(sel)) && (cur_bytes >= in_lvl));
      if (!is_in)
         prog_nxt = (total >= out_lvl);
      else if (bytes_only)
         prog_nxt = (total >= in_lvl);
      else
         prog_nxt = pkt_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         prog_q <= prog_nxt;
         seen_q <= 1'b1;
      end
   end

   // R5: OUT endpoint below its level never shows the flag next cycle
   a_r5_out_below_level: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(!is_in && (total < CNT_W'(thresh)))) |-> !prog_q);

   // R2: no committed packet and a nonzero packet setting keeps the flag low
   a_r2_no_pkts_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(is_in && !bytes_only && (pkts == '0) &&
                       (thresh[THRESH_W-1:IN_LVL_W] != '0))) |-> !prog_q);

   // R4: byte mode with total at or above the low level shows the flag
   a_r4_bytes_reach: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(is_in && bytes_only &&
                       (total >= CNT_W'(thresh[IN_LVL_W-1:0])))) |-> prog_q);

endmodule

// File: rtl/epf_edge_flags.sv
module epf_edge_flags #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             early,
   input  logic [CNT_W-1:0] total,
   input  logic [CNT_W-1:0] depth,
   output logic             empty_q,
   output logic             full_q
);

   logic [CNT_W:0] total_p1;
   logic [CNT_W:0] depth_x;
   logic           empty_nxt;
   logic           full_nxt;
   logic           seen_q;

   always_comb begin
      total_p1  = {1'b0, total} + 1'b1;
      depth_x   = {1'b0, depth};
      empty_nxt = early ? (total <= CNT_W'(1)) : (total == '0);
      full_nxt  = early ? (total_p1 >= depth_x) : ({1'b0, total} >= depth_x);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         full_q  <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         empty_q <= empty_nxt;
         full_q  <= full_nxt;
         seen_q  <= 1'b1;
      end
   end

   // R6: empty never reported with more than one entry present
   a_r6_empty_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && empty_q) |-> ($past(total) <= CNT_W'(1)));

   // R7: full never reported more than one entry short of depth
   a_r7_full_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && full_q) |-> ($past({1'b0, total}) + 1'b1 >= $past({1'b0, depth})));

   // R6: a truly empty FIFO is always reported empty
   a_r6_zero_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(total == '0)) |-> empty_q);

endmodule

// File: rtl/epf_status_pack.sv
module epf_status_pack
   import ep_flag_pkg::*;
#(
   parameter int unsigned SLOT = 0
) (
   input  flag_set_t   flags,
   output logic [7:0]  status_byte
);

   logic [3:0] nib;
   assign nib = {1'b0, flags.prog, flags.empty, flags.full};

   generate
      if (SLOT == 0) begin : g_low
         assign status_byte = {4'h0, nib};
      end else begin : g_high
         assign status_byte = {nib, 4'h0};
      end
   endgenerate

endmodule

// File: rtl/ep_flag_gen.sv
module ep_flag_gen
   import ep_flag_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PKT_W = 4,
   parameter int unsigned SLOT  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_is_in,
   input  logic                cfg_bytes_only,
   input  logic [THRESH_W-1:0] cfg_thresh,
   input  logic                cfg_in_early,
   input  logic                cfg_out_early,
   input  logic [PKT_W-1:0]    fifo_pkts,
   input  logic [CNT_W-1:0]    fifo_cur_bytes,
   input  logic [CNT_W-1:0]    fifo_total,
   input  logic [CNT_W-1:0]    fifo_depth,
   output logic                flag_prog,
   output logic                flag_empty,
   output logic                flag_full,
   output logic [7:0]          status_byte
);

   generate
      if (CNT_W < THRESH_W) begin : g_bad_cnt
         $error("CNT_W must cover the 13-bit threshold");
      end
      if (PKT_W < PKT_SEL_W) begin : g_bad_pkt
         $error("PKT_W must hold a packet count of 4");
      end
      if (SLOT > 1) begin : g_bad_slot
         $error("SLOT selects one of two nibbles");
      end
   endgenerate

   logic      early;
   flag_set_t flags;

   assign early = cfg_is_in ? cfg_in_early : cfg_out_early;

   epf_level_cmp #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_in      (cfg_is_in),
      .bytes_only (cfg_bytes_only),
      .thresh     (cfg_thresh),
      .pkts       (fifo_pkts),
      .cur_bytes  (fifo_cur_bytes),
      .total      (fifo_total),
      .prog_q     (flag_prog)
   );

   epf_edge_flags #(.CNT_W(CNT_W)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .early   (early),
      .total   (fifo_total),
      .depth   (fifo_depth),
      .empty_q (flag_empty),
      .full_q  (flag_full)
   );

   assign flags = '{prog: flag_prog, empty: flag_empty, full: flag_full};

   epf_status_pack #(.SLOT(SLOT)) u_pack (
      .flags       (flags),
      .status_byte (status_byte)
   );

   // R9: status nibble follows the registered flags with no extra delay
   a_r9_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status_byte) == $countones({flag_prog, flag_empty, flag_full}));

endmodule

// File: tb/ep_flag_gen_tb_top.sv
module ep_flag_gen_tb_top;

   localparam int unsigned CNT_W = 16;
   localparam int unsigned PKT_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_is_in = 1'b1;
   logic              cfg_bytes_only = 1'b0;
   logic [12:0]       cfg_thresh = '0;
   logic              cfg_in_early = 1'b0;
   logic              cfg_out_early = 1'b0;
   logic [PKT_W-1:0]  fifo_pkts = '0;
   logic [CNT_W-1:0]  fifo_cur_bytes = '0;
   logic [CNT_W-1:0]  fifo_total = '0;
   logic [CNT_W-1:0]  fifo_depth = 16'd512;
   logic              flag_prog, flag_empty, flag_full;
   logic [7:0]        status_byte;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   ep_flag_gen #(.CNT_W(CNT_W), .PKT_W(PKT_W), .SLOT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_is_in(cfg_is_in), .cfg_bytes_only(cfg_bytes_only),
      .cfg_thresh(cfg_thresh), .cfg_in_early(cfg_in_early), .cfg_out_early(cfg_out_early),
      .fifo_pkts(fifo_pkts), .fifo_cur_bytes(fifo_cur_bytes), .fifo_total(fifo_total),
      .fifo_depth(fifo_depth), .flag_prog(flag_prog), .flag_empty(flag_empty),
      .flag_full(flag_full), .status_byte(status_byte)
   );

   function automatic bit exp_prog();
      int sel, lo, pk, cur, tot;
      sel = int'(cfg_thresh[12:10]);
      if (sel > 4) sel = 4;
      lo  = int'(cfg_thresh[9:0]);
      pk  = int'(fifo_pkts);
      cur = int'(fifo_cur_bytes);
      tot = int'(fifo_total);
      if (!cfg_is_in) return tot >= int'(cfg_thresh);
      if (cfg_bytes_only) return tot >= lo;
      return (pk > sel) || (pk == sel && cur >= lo);
   endfunction

   function automatic bit exp_early();
      return cfg_is_in ? cfg_in_early : cfg_out_early;
   endfunction

   function automatic bit exp_empty();
      return exp_early() ? (fifo_total <= 1) : (fifo_total == 0);
   endfunction

   function automatic bit exp_full();
      return exp_early() ? (int'(fifo_total) + 1 >= int'(fifo_depth))
                         : (fifo_total >= fifo_depth);
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Sample at negedge, inputs applied at the previous negedge were registered at the posedge between
   task automatic check_all(input string req);
      bit ep, ee, ef;
      ep = exp_prog(); ee = exp_empty(); ef = exp_full();
      check(req, "prog",  int'(flag_prog),  int'(ep));
      check(req, "empty", int'(flag_empty), int'(ee));
      check(req, "full",  int'(flag_full),  int'(ef));
      check("R9", "status", int'(status_byte), int'({4'h0, 1'b0, ep, ee, ef}));
   endtask

   task automatic apply(input bit is_in, input bit bo, input logic [12:0] th,
                        input int pk, input int cur, input int tot, input int dep,
                        input bit ie, input bit oe);
      cfg_is_in = is_in; cfg_bytes_only = bo; cfg_thresh = th;
      fifo_pkts = PKT_W'(pk); fifo_cur_bytes = CNT_W'(cur);
      fifo_total = CNT_W'(tot); fifo_depth = CNT_W'(dep);
      cfg_in_early = ie; cfg_out_early = oe;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      // R1: reset state, inputs chosen so computed flags would differ
      fifo_total = 16'd600; fifo_pkts = 4'd7; fifo_cur_bytes = 16'd900;
      repeat (3) @(negedge clk);
      check("R1", "prog",  int'(flag_prog),  0);
      check("R1", "empty", int'(flag_empty), 1);
      check("R1", "full",  int'(flag_full),  0);
      check("R1", "status", int'(status_byte), 8'h02);
      rst_n = 1'b1;

      // R8: latency - change inputs at negedge, output unchanged until the next posedge
      cfg_is_in = 0; cfg_thresh = 13'd10; fifo_total = 16'd20; fifo_depth = 16'd512;
      #1;
      check("R8", "prog before edge", int'(flag_prog), 0);
      @(negedge clk);
      check("R8", "prog after edge", int'(flag_prog), 1);

      // R2: packet boundary, N=2, level 100
      apply(1,0,{3'd2,10'd100}, 2, 99, 300, 512, 0,0);  check_all("R2");
      check("R2", "pk=N cur<lvl", int'(flag_prog), 0);
      apply(1,0,{3'd2,10'd100}, 2, 100, 300, 512, 0,0); check_all("R2");
      check("R2", "pk=N cur=lvl", int'(flag_prog), 1);
      apply(1,0,{3'd2,10'd100}, 3, 0, 300, 512, 0,0);   check_all("R2");
      check("R2", "pk>N", int'(flag_prog), 1);
      apply(1,0,{3'd2,10'd100}, 1, 1023, 300, 512, 0,0); check_all("R2");
      check("R2", "pk<N", int'(flag_prog), 0);
      apply(1,0,{3'd0,10'd0}, 0, 0, 0, 512, 0,0);       check_all("R2");

      // R3: invalid encodings behave as 4
      for (int e = 5; e < 8; e++) begin
         apply(1,0,{3'(e),10'd50}, 4, 49, 300, 512, 0,0); check_all("R3");
         check("R3", "pk=4 below lvl", int'(flag_prog), 0);
         apply(1,0,{3'(e),10'd50}, 4, 50, 300, 512, 0,0); check_all("R3");
         check("R3", "pk=4 at lvl", int'(flag_prog), 1);
         apply(1,0,{3'(e),10'd1000}, 5, 0, 300, 512, 0,0); check_all("R3");
         check("R3", "pk=5", int'(flag_prog), 1);
      end

      // R4: byte mode ignores packet bits and counters
      apply(1,1,{3'd7,10'd200}, 0, 0, 199, 512, 0,0);   check_all("R4");
      check("R4", "below", int'(flag_prog), 0);
      apply(1,1,{3'd7,10'd200}, 0, 0, 200, 512, 0,0);   check_all("R4");
      check("R4", "at", int'(flag_prog), 1);
      apply(1,1,{3'd0,10'd200}, 15, 1023, 150, 512, 0,0); check_all("R4");
      check("R4", "counters ignored", int'(flag_prog), 0);

      // R5: OUT uses all 13 bits, ignores mode bit and packet counters
      apply(0,0,13'd1100, 15, 1023, 1099, 2048, 0,0);   check_all("R5");
      check("R5", "below", int'(flag_prog), 0);
      apply(0,1,13'd1100, 0, 0, 1100, 2048, 0,0);       check_all("R5");
      check("R5", "at", int'(flag_prog), 1);
      apply(0,0,13'd8191, 15, 1023, 8190, 16384, 0,0);  check_all("R5");
      check("R5", "top bits used", int'(flag_prog), 0);

      // R6/R7: edges with each direction's early enable, crossed
      for (int d = 0; d < 2; d++) begin
         for (int ie = 0; ie < 2; ie++) begin
            for (int oe = 0; oe < 2; oe++) begin
               apply(d[0],0,13'd5, 0,0, 0,   64, ie[0],oe[0]); check_all("R6");
               apply(d[0],0,13'd5, 0,0, 1,   64, ie[0],oe[0]); check_all("R6");
               apply(d[0],0,13'd5, 0,0, 2,   64, ie[0],oe[0]); check_all("R6");
               apply(d[0],0,13'd5, 0,0, 62,  64, ie[0],oe[0]); check_all("R7");
               apply(d[0],0,13'd5, 0,0, 63,  64, ie[0],oe[0]); check_all("R7");
               apply(d[0],0,13'd5, 0,0, 64,  64, ie[0],oe[0]); check_all("R7");
            end
         end
      end
      apply(1,0,13'd5, 0,0, 1, 64, 1,0);
      check("R6", "IN early at one", int'(flag_empty), 1);
      apply(1,0,13'd5, 0,0, 63, 64, 0,1);
      check("R7", "IN uses IN enable", int'(flag_full), 0);

      // Random mix, R8 latency checked on every step
      for (int i = 0; i < 3000; i++) begin
         int dep, tot;
         dep = int'($urandom_range(4, 1500));
         case ($urandom_range(0, 3))
            0: tot = int'($urandom_range(0, 2));
            1: tot = dep - 2 + int'($urandom_range(0, 3));
            default: tot = int'($urandom_range(0, dep + 1));
         endcase
         apply(1'($urandom), 1'($urandom), 13'($urandom),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 1100)),
               tot, dep, 1'($urandom), 1'($urandom));
         check_all("R8");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule